// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `N` bits and returns their full `2N`-bit signed product. It works iteratively. Each clock step takes two multiplier bits together with the bit just below them. These three bits choose one signed multiple of the multiplicand: zero, plus or minus once, or plus or minus twice. That multiple goes into a sign-extended accumulator, and the combined accumulator and multiplier register then shifts right arithmetically by two places. An `N`-bit multiply therefore takes `N/2` steps instead of the `N` steps that plain add-and-shift would need.

Control is a pair of plain pins. A one-cycle `start` pulse while the block is idle captures both operands. A one-cycle `done` pulse marks the cycle in which `product` first shows the new result. The block has no valid/ready handshake and no back-pressure: `start` is honoured only while idle and is dropped otherwise. A result is never stalled, and `product` keeps its value until the next completion. `N` must be even and at least 2.

Top module: `booth_r4_mult`

## Requirements
- R1: While `rst_n` is low, and after reset until the first completion, `product` reads 0 and `done` reads 0.
- R2: A `start` sampled high at a rising edge while idle is accepted. `done` is then high for exactly the one cycle that follows the `N/2`-th rising edge after the accepting edge.
- R3: In the `done` cycle, `product` equals the signed product of the `mcand` and `mplier` values sampled at the accepting edge, as a `2N`-bit two's-complement number.
- R4: Step k (k = 0 .. N/2-1) reads the window {mplier[2k+1], mplier[2k], mplier[2k-1]}, where an implicit 0 stands in for mplier[-1]. It adds 0 for 000 and 111, +M for 001 and 010, +2M for 011, -2M for 100, and -M for 101 and 110, with M the multiplicand. -M and -2M are formed as two's complements. Every multiplier bit pattern gives the result of R3.
- R5: A `start` pulse while a multiply is in progress is ignored. It changes neither the result nor the `done` timing of the running operation.
- R6: `product` changes only on the edge that raises `done`, and holds its value in every other cycle.
- R7: Extreme operands are exact. The most negative value squared gives +2^(2N-2). With N=6, 13 x (-6) gives 12'b111110110010.
- R8: A `start` sampled in the `done` cycle is accepted, so operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; honoured only while idle |
| mcand | input | N | Signed multiplicand, sampled on the accepting edge |
| mplier | input | N | Signed multiplier, sampled on the accepting edge |
| product | output | 2N | Signed product, updated at completion and then held |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block twice, once with N=8 and once with N=6. The 6-bit copy runs every one of the 4096 operand pairs, so every recoding window, every sign combination and both extreme values occur at every step position, and it carries the stated 13 x (-6) case. The 8-bit copy is compared on every clock against a behavioural cycle model. It covers all 256 multipliers against fixed multiplicands of both signs, random operands, back-to-back starts and starts issued while busy.

// File: rtl/booth_r4_pkg.sv
`timescale 1ns/1ps
package booth_r4_pkg;
  // Signed digit chosen by one recoding window
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_N1   = 3'd3,
    DIG_N2   = 3'd4
  } booth_digit_e;
endpackage

// File: rtl/booth_r4_recode.sv
`timescale 1ns/1ps
// Maps a three-bit window {upper, middle, lower} to a signed digit (R4)
module booth_r4_recode
  import booth_r4_pkg::*;
(
  input  logic [2:0]   window,
  output booth_digit_e digit
);
  always_comb begin
    unique case (window)
      3'b001, 3'b010: digit = DIG_P1;
      3'b011:         digit = DIG_P2;
      3'b100:         digit = DIG_N2;
      3'b101, 3'b110: digit = DIG_N1;
      default:        digit = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_r4_multiple.sv
`timescale 1ns/1ps
// Forms the selected signed multiple of the multiplicand, sign-extended
module booth_r4_multiple
  import booth_r4_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]  mcand,
  input  booth_digit_e  digit,
  output logic [N+1:0]  addend
);
  localparam int unsigned AW = N + 2;

  logic [AW-1:0] once;
  logic [AW-1:0] twice;

  assign once  = {{2{mcand[N-1]}}, mcand};
  assign twice = {mcand[N-1], mcand, 1'b0};

  always_comb begin
    unique case (digit)
      DIG_P1:  addend = once;
      DIG_P2:  addend = twice;
      DIG_N1:  addend = ~once + AW'(1);
      DIG_N2:  addend = ~twice + AW'(1);
      default: addend = '0;
    endcase
  end
endmodule

// File: rtl/booth_r4_seq.sv
`timescale 1ns/1ps
// Step sequencer: accepts start while idle, counts STEPS iterations
module booth_r4_seq #(
  parameter int unsigned STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] cnt;

  assign load = start & ~busy;
  assign step = busy;
  assign last = busy && (cnt == CW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/booth_r4_mult.sv
`timescale 1ns/1ps
// Signed radix-4 Booth multiplier, two multiplier bits per clock
module booth_r4_mult
  import booth_r4_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int unsigned STEPS = N / 2;
  localparam int unsigned AW    = N + 2;

  logic          load, step, last, busy;
  logic [AW-1:0] acc;
  logic [N-1:0]  qreg;
  logic          qm1;
  logic [N-1:0]  mreg;
  booth_digit_e  dig;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;
  logic [AW-1:0] acc_nx;
  logic [N-1:0]  q_nx;

  booth_r4_seq #(.STEPS(STEPS)) i_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .load (load),
    .step (step),
    .last (last),
    .busy (busy),
    .done (done)
  );

  booth_r4_recode i_recode (
    .window({qreg[1:0], qm1}),
    .digit (dig)
  );

  booth_r4_multiple #(.N(N)) i_multiple (
    .mcand (mreg),
    .digit (dig),
    .addend(addend)
  );

  assign sum    = acc + addend;
  assign acc_nx = {{2{sum[AW-1]}}, sum[AW-1:2]};

  generate
    if (N == 2) begin : g_q_narrow
      assign q_nx = sum[1:0];
    end else begin : g_q_wide
      assign q_nx = {sum[1:0], qreg[N-1:2]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      qreg <= '0;
      qm1  <= 1'b0;
      mreg <= '0;
    end else if (load) begin
      acc  <= '0;
      qreg <= mplier;
      qm1  <= 1'b0;
      mreg <= mcand;
    end else if (step) begin
      acc  <= acc_nx;
      qreg <= q_nx;
      qm1  <= qreg[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    product <= '0;
    else if (last) product <= {acc_nx[N-1:0], q_nx};
  end
endmodule

// File: rtl/booth_r4_mult_chk.sv
`timescale 1ns/1ps
module booth_r4_mult_chk #(
  parameter int unsigned N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] product,
  input logic           done,
  input logic           busy
);
  localparam int unsigned PW    = 2 * N;
  localparam int unsigned STEPS = N / 2;
  localparam int unsigned LW    = $clog2(STEPS + 2);

  logic [PW-1:0] exp_q;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      lat   <= '0;
    end else if (start && !busy) begin
      exp_q <= PW'($signed(mcand)) * PW'($signed(mplier));
      lat   <= '0;
    end else if (lat != LW'(STEPS + 1)) begin
      lat <= lat + LW'(1);
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LW'(STEPS)));
  p_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == exp_q));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind booth_r4_mult booth_r4_mult_chk #(.N(N)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .mcand  (mcand),
  .mplier (mplier),
  .product(product),
  .done   (done),
  .busy   (busy)
);

// File: tb/test_booth_r4_mult.sv
`timescale 1ns/1ps
module test_booth_r4_mult;
  localparam int N = 8;
  localparam int STEPS = N / 2;
  localparam int PW = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0;
  logic [N-1:0]  a = '0, b = '0;
  logic [PW-1:0] product;
  logic          done;

  logic         start6 = 1'b0;
  logic [5:0]   a6 = '0, b6 = '0;
  logic [11:0]  product6;
  logic         done6;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  booth_r4_mult #(.N(N)) i_booth_r4_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(a), .mplier(b),
    .product(product), .done(done));

  booth_r4_mult #(.N(6)) i_booth_r4_mult_w6 (
    .clk(clk), .rst_n(rst_n), .start(start6), .mcand(a6), .mplier(b6),
    .product(product6), .done(done6));

  // Behavioural cycle model of the 8-bit instance
  bit            m_busy;
  int            m_cnt;
  bit            m_done;
  logic [PW-1:0] m_prod, m_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_prod = '0; m_val = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_prod = m_val;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = STEPS;
        m_val = PW'($signed(a) * $signed(b));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (done !== m_done) begin
        n_fail++;
        $display("FAIL R2 done timing: actual %b expected %b at %0t", done, m_done, $time);
      end
      n_chk++;
      if (product !== m_prod) begin
        n_fail++;
        $display("FAIL %s product: actual %h expected %h at %0t",
                 m_done ? "R3" : "R6", product, m_prod, $time);
      end
    end
  end

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a negedge; returns at the negedge where done is high
  task automatic op8(input string req, input logic [N-1:0] x, input logic [N-1:0] y,
                     input bit poke_busy);
    int waits;
    logic [PW-1:0] e;
    e = PW'($signed(x) * $signed(y));
    start = 1'b1; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    waits = 0;
    if (poke_busy) begin
      // R5: start while busy with other operands must be ignored
      start = 1'b1; a = ~x; b = y + 8'd3;
      @(negedge clk); waits++;
      start = 1'b0;
    end
    while (!done && waits < 40) begin
      @(negedge clk); waits++;
    end
    check({req, " latency"}, PW'(waits), PW'(STEPS));
    check({req, " value"}, product, e);
  endtask

  task automatic op6(input string req, input logic [5:0] x, input logic [5:0] y);
    int waits;
    logic [11:0] e;
    e = 12'($signed(x) * $signed(y));
    start6 = 1'b1; a6 = x; b6 = y;
    @(negedge clk);
    start6 = 1'b0;
    waits = 0;
    while (!done6 && waits < 40) begin
      @(negedge clk); waits++;
    end
    n_chk++;
    if (waits != 3 || product6 !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h after %0d expected %h after 3", req, product6, waits, e);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset product", product, '0);
    check("R1 reset done", PW'(done), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle product", product, '0);
    check("R1 idle done", PW'(done), '0);

    // R7 stated 6-bit case: 13 x -6 = 111110110010
    op6("R7 worked", 6'd13, 6'b111010);
    n_chk++;
    if (product6 !== 12'b111110110010) begin
      n_fail++;
      $display("FAIL R7: actual %b expected 111110110010", product6);
    end
    // R4 R3 exhaustive on 6 bits
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        op6("R4 exhaustive6", 6'(x), 6'(y));
    @(negedge clk);

    // R7 extremes on 8 bits
    op8("R7 min*min", 8'h80, 8'h80, 0);
    check("R7 min*min exact", product, 16'h4000);
    op8("R7 min*max", 8'h80, 8'h7F, 0);
    op8("R7 max*max", 8'h7F, 8'h7F, 0);
    op8("R3 zero", 8'h00, 8'h80, 0);
    op8("R3 -1*-1", 8'hFF, 8'hFF, 0);
    // R4: every multiplier pattern against a negative and a positive multiplicand
    for (int y = 0; y < 256; y++) op8("R4 neg mcand", 8'hDB, 8'(y), 0);
    for (int y = 0; y < 256; y++) op8("R4 pos mcand", 8'h35, 8'(y), 0);
    // R5: starts while busy
    for (int k = 0; k < 20; k++) op8("R5 busy start", 8'($urandom), 8'($urandom), 1);
    // R8: the back-to-back calls above start in the done cycle; random run
    for (int k = 0; k < 400; k++) op8("R8 back-to-back", 8'($urandom), 8'($urandom), 0);
    // R6: product holds while idle
    repeat (6) @(negedge clk);
    op8("R6 before idle", 8'h12, 8'hF3, 0);
    repeat (5) begin
      @(negedge clk);
      check("R6 hold", product, PW'($signed(8'h12) * $signed(8'hF3)));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule